// File: doc/BRIEF.md
# UART Boot Stub Sequencer

This block runs the hardware side of serial boot mode. While the boot-mode input is high, it waits for the receive line to go low. It counts how many clock cycles the line stays low while a single all-zero byte arrives. That low stretch is the start bit plus eight zero data bits. The block divides the count by nine to get the per-bit divisor and hands it to an external UART. In the same step it loads that UART's control word with a fixed value.

Once the divisor is latched, the block asks the UART to send one acknowledge byte. When the UART reports that the byte has gone out, the block takes the next 32 correctly framed received bytes. It writes them one after another into a fixed on-chip RAM window that starts at 0x00FA40. After the last write it emits a one-cycle jump request aimed at the start of that window, then goes idle until reset.

For the whole time boot mode is active, the block also does three things. It holds the watchdog disabled. It enables the serial transmit pin driver. It sends instruction fetches that fall inside the internal flash range to a separate test memory, while data reads in that range still go to the flash.

Top module: `boot_seq`

## Requirements
- R1: With boot mode high, when the receive line stays low for L sampled cycles and then returns high, `baud_load` is high for exactly one cycle, starting the cycle after the line is seen high. During that cycle `baud_div` equals floor(L/9), and `ser_ctrl` reads 0x8011. `ser_ctrl` is 0x0000 after reset.
- R2: `tx_req` is high for exactly one cycle, the cycle after `baud_load`, with `tx_data` equal to the acknowledge parameter (default 0xD5). It is never high in the same cycle as `baud_load`.
- R3: Between the acknowledge request and the `tx_done` pulse, received bytes cause no RAM write.
- R4: In the load phase, each correctly framed received byte (`rx_valid` high with `rx_ferr` low) drives `ram_we` high in that same cycle. `ram_wdata` is the byte, and `ram_addr` is 0x00FA40 plus the number of bytes already written. Addresses therefore run from 0x00FA40 to 0x00FA5F.
- R5: A byte that arrives with `rx_ferr` high is not written, and it does not advance the address.
- R6: The cycle after the 32nd write, `jump_req` is high for exactly one cycle, with `jump_addr` = 0x00FA40.
- R7: After the jump request, further received bytes cause no RAM write and no second jump, until reset.
- R8: `wdt_disable` and `txd_oe` both equal `boot_mode`.
- R9: `sel_test` is high exactly when `boot_mode` is high, `fetch_is_code` is high, and 0x010000 <= `fetch_addr` <= 0x08FFFF. Data accesses (`fetch_is_code` low) never select the test memory.
- R10: While boot mode is low, a low receive line starts no measurement. No `baud_load` or `tx_req` appears, and a sequencer that was already running returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Boot-mode strap, high while serial boot is selected |
| rx_line | input | 1 | Synchronised receive line level |
| rx_valid | input | 1 | UART has a received byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error on the byte in `rx_data` |
| tx_done | input | 1 | UART finished sending the acknowledge byte |
| fetch_addr | input | 24 | Address of the current core access |
| fetch_is_code | input | 1 | High when that access is an instruction fetch |
| baud_div | output | 16 | Measured per-bit divisor |
| baud_load | output | 1 | One-cycle strobe to load `baud_div` and `ser_ctrl` |
| ser_ctrl | output | 16 | UART control word |
| tx_req | output | 1 | One-cycle request to send `tx_data` |
| tx_data | output | 8 | Acknowledge byte |
| txd_oe | output | 1 | Transmit pin output enable |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 24 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| jump_req | output | 1 | One-cycle jump request |
| jump_addr | output | 24 | Jump target |
| wdt_disable | output | 1 | Holds the watchdog disabled |
| sel_test | output | 1 | Steers the current access to the test memory |

## Verification
Fetch steering and RAM writes are independent paths that fire together. While each of the 32 stub bytes is written, the bench presents a different fetch address and access type. The addresses are taken from the edges of the flash range and points just outside them. In that one cycle the bench judges both the write strobe, address and data, and the steering decision, each against values it computes itself. A second overlap is a framing error and a correctly framed byte sharing the load loop: bytes with errors are inserted at a fixed stride, and the expected address is advanced only for good bytes, so any miscount shows at every later write.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int ADDR_W = 24;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] STUB_BASE  = 24'h00FA40;
    localparam logic [ADDR_W-1:0] FLASH_LO   = 24'h010000;
    localparam logic [ADDR_W-1:0] FLASH_HI   = 24'h08FFFF;
    localparam logic [15:0]       SER_CTRL_BOOT = 16'h8011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEAS,
        ST_BAUD,
        ST_ACK,
        ST_AWAIT,
        ST_LOAD,
        ST_JUMP,
        ST_DONE
    } boot_st_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } ram_wr_t;

    function automatic logic in_flash(input logic [ADDR_W-1:0] a);
        return (a >= FLASH_LO) && (a <= FLASH_HI);
    endfunction

endpackage

// File: rtl/boot_baud_meas.sv
module boot_baud_meas #(
    parameter int CNT_W   = 16,
    parameter int BIT_CNT = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             extend,
    output logic [CNT_W-1:0] divisor
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (start) begin
            low_cnt <= CNT_W'(1);
        end else if (extend && (low_cnt != CNT_MAX)) begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    // the zero byte spans the start bit plus all data bits
    assign divisor = low_cnt / CNT_W'(BIT_CNT);

endmodule

// File: rtl/boot_load_ctr.sv
module boot_load_ctr #(
    parameter int NBYTES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic adv,
    output logic [$clog2(NBYTES)-1:0] idx,
    output logic last
);
    localparam int IDX_W = $clog2(NBYTES);
    localparam logic [IDX_W-1:0] TERM = IDX_W'(NBYTES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + IDX_W'(1);
        end
    end

    assign last = (idx == TERM);

endmodule

// File: rtl/boot_fetch_steer.sv
module boot_fetch_steer
    import boot_pkg::*;
(
    input  logic              boot_mode,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_code,
    output logic              to_test
);
    always_comb begin
        to_test = boot_mode && acc_is_code && in_flash(acc_addr);
    end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          NBYTES   = 32,
    parameter logic [7:0]  ACK_BYTE = 8'hD5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_mode,
    input  logic              rx_line,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_ferr,
    input  logic              tx_done,
    input  logic [23:0]       fetch_addr,
    input  logic              fetch_is_code,
    output logic [CNT_W-1:0]  baud_div,
    output logic              baud_load,
    output logic [15:0]       ser_ctrl,
    output logic              tx_req,
    output logic [7:0]        tx_data,
    output logic              txd_oe,
    output logic              ram_we,
    output logic [23:0]       ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              jump_req,
    output logic [23:0]       jump_addr,
    output logic              wdt_disable,
    output logic              sel_test
);
    localparam int IDX_W = $clog2(NBYTES);

    boot_st_e         st, st_nx;
    logic             meas_start, meas_ext;
    logic [IDX_W-1:0] idx;
    logic             idx_last;
    ram_wr_t          wr;

    assign meas_start = boot_mode && (st == ST_IDLE) && !rx_line;
    assign meas_ext   = boot_mode && (st == ST_MEAS) && !rx_line;

    boot_baud_meas #(.CNT_W(CNT_W), .BIT_CNT(9)) u_meas (
        .clk     (clk),
        .rst     (rst),
        .start   (meas_start),
        .extend  (meas_ext),
        .divisor (baud_div)
    );

    always_comb begin
        wr.we   = (st == ST_LOAD) && rx_valid && !rx_ferr;
        wr.addr = STUB_BASE + ADDR_W'(idx);
        wr.data = rx_data;
    end

    boot_load_ctr #(.NBYTES(NBYTES)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (st == ST_BAUD),
        .adv   (wr.we),
        .idx   (idx),
        .last  (idx_last)
    );

    boot_fetch_steer u_steer (
        .boot_mode   (boot_mode),
        .acc_addr    (fetch_addr),
        .acc_is_code (fetch_is_code),
        .to_test     (sel_test)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (!rx_line)           st_nx = ST_MEAS;
            ST_MEAS:  if (rx_line)            st_nx = ST_BAUD;
            ST_BAUD:                          st_nx = ST_ACK;
            ST_ACK:                           st_nx = ST_AWAIT;
            ST_AWAIT: if (tx_done)            st_nx = ST_LOAD;
            ST_LOAD:  if (wr.we && idx_last)  st_nx = ST_JUMP;
            ST_JUMP:                          st_nx = ST_DONE;
            ST_DONE:                          st_nx = ST_DONE;
            default:                          st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !boot_mode) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_ctrl <= '0;
        end else if (boot_mode && (st == ST_MEAS) && rx_line) begin
            ser_ctrl <= SER_CTRL_BOOT;
        end
    end

    assign baud_load   = (st == ST_BAUD);
    assign tx_req      = (st == ST_ACK);
    assign tx_data     = ACK_BYTE;
    assign ram_we      = wr.we;
    assign ram_addr    = wr.addr;
    assign ram_wdata   = wr.data;
    assign jump_req    = (st == ST_JUMP);
    assign jump_addr   = STUB_BASE;
    assign wdt_disable = boot_mode;
    assign txd_oe      = boot_mode;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        boot_mode,
    input logic        rx_valid,
    input logic        rx_ferr,
    input logic        baud_load,
    input logic        tx_req,
    input logic        ram_we,
    input logic [23:0] ram_addr,
    input logic        jump_req,
    input logic [23:0] jump_addr
);
    logic jumped;

    always_ff @(posedge clk) begin
        if (rst || !boot_mode) begin
            jumped <= 1'b0;
        end else if (jump_req) begin
            jumped <= 1'b1;
        end
    end

    // R2
    ack_after_baud_chk: assert property (@(posedge clk) disable iff (rst)
        (baud_load && boot_mode) |=> tx_req);

    // R2
    ack_not_with_baud_chk: assert property (@(posedge clk) disable iff (rst)
        baud_load |-> !tx_req);

    // R4
    write_window_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr >= 24'h00FA40 && ram_addr <= 24'h00FA5F));

    // R5
    ferr_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ferr) |-> !ram_we);

    // R6
    jump_single_chk: assert property (@(posedge clk) disable iff (rst)
        jump_req |=> !jump_req);

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        jump_req |-> (jump_addr == 24'h00FA40));

    // R7
    quiet_after_jump_chk: assert property (@(posedge clk) disable iff (rst)
        jumped |-> (!ram_we && !jump_req));

    // R10
    idle_without_boot_chk: assert property (@(posedge clk) disable iff (rst)
        !boot_mode |=> (!baud_load && !tx_req));

endmodule

bind boot_seq boot_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .boot_mode (boot_mode),
    .rx_valid  (rx_valid),
    .rx_ferr   (rx_ferr),
    .baud_load (baud_load),
    .tx_req    (tx_req),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .jump_req  (jump_req),
    .jump_addr (jump_addr)
);

// File: tb/test_boot_seq.sv
module test_boot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_mode = 1'b1;
    logic        rx_line = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ferr = 1'b0;
    logic        tx_done = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        fetch_is_code = 1'b0;
    logic [15:0] baud_div;
    logic        baud_load;
    logic [15:0] ser_ctrl;
    logic        tx_req;
    logic [7:0]  tx_data;
    logic        txd_oe;
    logic        ram_we;
    logic [23:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        jump_req;
    logic [23:0] jump_addr;
    logic        wdt_disable;
    logic        sel_test;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_seq i_boot_seq (
        .clk(clk), .rst(rst), .boot_mode(boot_mode), .rx_line(rx_line),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .tx_done(tx_done), .fetch_addr(fetch_addr),
        .fetch_is_code(fetch_is_code), .baud_div(baud_div),
        .baud_load(baud_load), .ser_ctrl(ser_ctrl), .tx_req(tx_req),
        .tx_data(tx_data), .txd_oe(txd_oe), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .jump_req(jump_req),
        .jump_addr(jump_addr), .wdt_disable(wdt_disable), .sel_test(sel_test)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic exp_steer(input logic b, input logic code, input logic [23:0] a);
        return b && code && (a >= 24'h010000) && (a <= 24'h08FFFF);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_line = 1'b1; rx_valid = 1'b0; tx_done = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drives a zero byte of L low cycles and checks measurement and ack
    task automatic measure(input int L);
        rx_line = 1'b0;
        repeat (L) @(negedge clk);
        rx_line = 1'b1;
        check("R2 no ack yet", tx_req, 0);
        @(negedge clk);
        check("R1 baud_load", baud_load, 1);
        check("R1 divisor", baud_div, 32'(L / 9));
        check("R1 ser_ctrl", ser_ctrl, 32'h8011);
        check("R2 ack not with load", tx_req, 0);
        @(negedge clk);
        check("R1 load single", baud_load, 0);
        check("R2 tx_req", tx_req, 1);
        check("R2 tx_data", tx_data, 32'hD5);
        @(negedge clk);
        check("R2 tx_req single", tx_req, 0);
    endtask

    initial begin
        for (int c = 0; c < WD_CYCLES; c++) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    logic [23:0] probe [8];
    initial begin
        probe[0] = 24'h00FFFF; probe[1] = 24'h010000; probe[2] = 24'h08FFFF;
        probe[3] = 24'h090000; probe[4] = 24'h04A5A5; probe[5] = 24'h00FA40;
        probe[6] = 24'hFFFFFF; probe[7] = 24'h010001;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset ser_ctrl", ser_ctrl, 0);
        check("R1 reset baud_load", baud_load, 0);
        check("R2 reset tx_req", tx_req, 0);
        check("R4 reset ram_we", ram_we, 0);
        check("R6 reset jump", jump_req, 0);
        check("R8 wdt_disable", wdt_disable, 1);
        check("R8 txd_oe", txd_oe, 1);

        // R1 sweep of low durations
        foreach (probe[i]) begin end
        for (int k = 0; k < 6; k++) begin
            int L;
            L = (k == 0) ? 9 : (k == 1) ? 17 : (k == 2) ? 18 :
                (k == 3) ? 63 : (k == 4) ? 100 : 1000;
            do_reset();
            measure(L);
        end

        // R10: boot mode low, line low starts nothing
        do_reset();
        boot_mode = 1'b0;
        #1;
        check("R8 wdt off", wdt_disable, 0);
        check("R8 txd_oe off", txd_oe, 0);
        rx_line = 1'b0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (c == 20) rx_line = 1'b1;
            if (baud_load || tx_req) check("R10 no start", 1, 0);
        end
        check("R10 ser_ctrl untouched", ser_ctrl, 0);
        for (int i = 0; i < 8; i++) begin
            fetch_addr = probe[i]; fetch_is_code = 1'b1;
            #1;
            check("R9 no steer outside boot", sel_test, 0);
        end
        boot_mode = 1'b1;

        // full load with framing errors and concurrent steering
        do_reset();
        measure(45);
        // R3: stray byte before tx_done
        rx_valid = 1'b1; rx_data = 8'hAA; rx_ferr = 1'b0;
        #1;
        check("R3 ignored before ack done", ram_we, 0);
        @(negedge clk);
        rx_valid = 1'b0; tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        begin
            int n;
            int k;
            n = 0; k = 0;
            while (n < 32) begin
                logic fe;
                logic [7:0] d;
                fe = ((k % 6) == 3);
                d  = 8'((k * 7 + 3) & 8'hFF);
                rx_valid = 1'b1; rx_data = d; rx_ferr = fe;
                fetch_addr = probe[k % 8]; fetch_is_code = k[0] ^ k[3];
                #1;
                check("R9 steer during load", sel_test,
                      exp_steer(1'b1, fetch_is_code, fetch_addr));
                check("R6 no early jump", jump_req, 0);
                if (fe) begin
                    check("R5 ferr not written", ram_we, 0);
                end else begin
                    check("R4 write strobe", ram_we, 1);
                    check("R4 write addr", ram_addr, 32'(24'h00FA40 + n));
                    check("R4 write data", ram_wdata, d);
                    n++;
                end
                @(negedge clk);
                k++;
            end
            rx_valid = 1'b0;
            #1;
            check("R6 jump_req", jump_req, 1);
            check("R6 jump_addr", jump_addr, 32'h00FA40);
            @(negedge clk);
            check("R6 jump single", jump_req, 0);
            for (int j = 0; j < 4; j++) begin
                rx_valid = 1'b1; rx_data = 8'(j); rx_ferr = 1'b0;
                #1;
                check("R7 no write after jump", ram_we, 0);
                check("R7 no second jump", jump_req, 0);
                @(negedge clk);
            end
            rx_valid = 1'b0;
        end
        check("R8 still boot", wdt_disable, 1);
        for (int i = 0; i < 8; i++) begin
            fetch_addr = probe[i]; fetch_is_code = 1'b0;
            #1;
            check("R9 data read not steered", sel_test, 0);
        end
        finish_up();
    end

endmodule